// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits behind the receive path of an Ethernet MAC and decides whether a frame is kept, based only on its 48-bit destination address. The six destination bytes arrive one per accepted cycle, first byte first. A start strobe marks the first byte. As the bytes arrive, the filter compares each one against five stored addresses: the station address and four exact-match multicast slots. In the same pass it builds a reflected CRC-32 over the bytes, so that a 64-bit multicast hash table can be looked up as soon as the last byte is in.

Software programs the filter through a 16-bit write port. Each stored address takes three 16-bit words. The word at offset w holds address byte 2w in bits 7:0 and byte 2w+1 in bits 15:8. Consecutive address slots are four word addresses apart. Software writes all ones into exact-match slots it does not use. When it has more multicast groups than slots, it moves them into the hash table. Two mode bits widen acceptance: one accepts every frame, the other accepts every group-addressed frame.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_accept` are 0. The station address resets to all zeros, every exact-match slot resets to all ones, the hash table resets to zero and both mode bits reset to 0.
- R2: A frame whose six bytes all equal the station address is accepted. A frame that differs from it in any single byte, and meets no other acceptance rule, is rejected.
- R3: The broadcast address (all six bytes 0xFF) is always accepted.
- R4: A frame equal to any of the four exact-match slots is accepted. Slot k (k = 0..3) uses word addresses 4(k+1)+0..2. A slot holding all ones matches nothing but broadcast.
- R5: With the accept-all-multicast bit (bit 1 of the control word at word address 3) set, every frame with the group bit (bit 0 of byte 0) set is accepted. Frames with the group bit clear are not affected by this bit.
- R6: With the promiscuous bit (bit 0 of the control word at word address 3) set, every frame is accepted.
- R7: The hash index is bits 31:26 of the reflected CRC-32 register. The register uses polynomial 0xEDB88320, starts at all ones, takes the six bytes least significant bit first, and gets no final inversion. Index bits 5:4 select the hash word at word address 20+sel, and index bits 3:0 = n select bit 15−n of that word. A group-addressed frame whose hash bit is set is accepted. A frame with the group bit clear is never accepted through the hash table.
- R8: `dec_valid` pulses high for exactly one cycle. It rises on the clock edge that takes the sixth byte. `dec_accept` carries the decision in that cycle and is 0 in every other cycle.
- R9: A byte taken with `da_start` high always restarts the address at byte 0 and discards any partial address, including all comparison and CRC state.
- R10: Cycles with `da_valid` low between bytes are skipped without effect. Bytes taken without `da_start` when no address is in progress are ignored and produce no decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_we | input | 1 | Configuration word write enable |
| cfg_addr | input | ADDR_W (5) | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| da_start | input | 1 | Marks the byte taken in this cycle as byte 0 |
| da_valid | input | 1 | Destination byte valid |
| da_byte | input | 8 | Destination address byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Accept flag, meaningful while `dec_valid` is high |

## Verification
The bound checker watches the decision strobe on every cycle. It checks that the strobe is a single-cycle pulse that follows a taken byte, that the accept flag stays low outside it, that a start byte never produces a decision in the next cycle, and that promiscuous mode always accepts. Whether a given address is accepted shows up only in the bench scenarios:
- single-byte corruptions of the station address;
- exact-slot hits and the all-ones disabling of slots;
- the mode bits;
- a sweep of 64 group addresses through the hash table, each tested against a table with only its own bit set and against the complement of that table;
- restarts in mid-address and gaps between bytes.

// File: rtl/dafl_pkg.sv
package dafl_pkg;
  localparam int ADDR_BYTES     = 6;
  localparam int WORD_W         = 16;
  localparam int WORDS_PER_ADDR = 3;
  localparam int HASH_WORDS     = 4;
  localparam int HASH_IDX_W     = 6;
  localparam int CRC_W          = 32;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef logic [WORDS_PER_ADDR*WORD_W-1:0] mac_addr_t;

  // bit 0: accept everything, bit 1: accept all group addresses
  typedef struct packed {
    logic all_multi;
    logic promisc;
  } mode_t;

  // one byte of a reflected CRC, least significant bit first
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c,
                                                     input logic [7:0] b);
    logic [CRC_W-1:0] r;
    r = c ^ {{(CRC_W-8){1'b0}}, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/dafl_cfg_regs.sv
module dafl_cfg_regs
  import dafl_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 5
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  we,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [WORD_W-1:0]                     wdata,
  output mac_addr_t                             station,
  output mac_addr_t [NUM_SLOTS-1:0]             mc_addr,
  output logic [HASH_WORDS-1:0][WORD_W-1:0]     hash_tbl,
  output mode_t                                 mode
);
  localparam int SEL_W    = ADDR_W - 2;
  localparam int HASH_SEL = NUM_SLOTS + 1;

  logic [SEL_W-1:0] sel;
  logic [1:0]       word;
  logic [5:0]       woff;

  assign sel  = addr[ADDR_W-1:2];
  assign word = addr[1:0];
  assign woff = {word, 4'b0000};

  // station address and mode word share group 0
  mac_addr_t station_q, station_d;
  mode_t     mode_q, mode_d;
  logic      station_en, mode_en;

  assign station_en = we && (sel == '0) && (word != 2'd3);
  assign mode_en    = we && (sel == '0) && (word == 2'd3);

  always_comb begin
    station_d = station_q;
    mode_d    = mode_q;
    if (station_en) station_d[woff +: WORD_W] = wdata;
    if (mode_en)    mode_d = mode_t'(wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      station_q <= '0;
      mode_q    <= '0;
    end else begin
      if (station_en) station_q <= station_d;
      if (mode_en)    mode_q    <= mode_d;
    end
  end

  // exact-match multicast slots, reset to the disabled (all ones) pattern
  mac_addr_t [NUM_SLOTS-1:0] mc_q;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    mac_addr_t slot_d;
    logic      slot_en;

    assign slot_en = we && (sel == SEL_W'(k + 1)) && (word != 2'd3);

    always_comb begin
      slot_d = mc_q[k];
      if (slot_en) slot_d[woff +: WORD_W] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mc_q[k] <= '1;
      else if (slot_en) mc_q[k] <= slot_d;
    end
  end

  // hash table words
  logic [HASH_WORDS-1:0][WORD_W-1:0] hash_q, hash_d;
  logic hash_en;

  assign hash_en = we && (sel == SEL_W'(HASH_SEL));

  always_comb begin
    hash_d = hash_q;
    if (hash_en) hash_d[word] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hash_q <= '0;
    else if (hash_en) hash_q <= hash_d;
  end

  assign station  = station_q;
  assign mc_addr  = mc_q;
  assign hash_tbl = hash_q;
  assign mode     = mode_q;
endmodule

// File: rtl/dafl_addr_cmp.sv
module dafl_addr_cmp
  import dafl_pkg::*;
#(
  parameter int POS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             first,
  input  logic [POS_W-1:0] pos,
  input  logic [7:0]       data,
  input  mac_addr_t        ref_addr,
  output logic             hit_now
);
  logic       hit_q, hit_d;
  logic [7:0] ref_byte;

  assign ref_byte = ref_addr[{pos, 3'b000} +: 8];
  assign hit_now  = (first | hit_q) & (data == ref_byte);

  always_comb begin
    hit_d = hit_q;
    if (step) hit_d = hit_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hit_q <= 1'b0;
    else if (step) hit_q <= hit_d;
  end
endmodule

// File: rtl/dafl_hash_crc.sv
module dafl_hash_crc
  import dafl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step,
  input  logic                  first,
  input  logic [7:0]            data,
  output logic [HASH_IDX_W-1:0] hash_idx
);
  logic [CRC_W-1:0] crc_q, crc_d, crc_base;

  assign crc_base = first ? '1 : crc_q;

  always_comb begin
    crc_d = crc_q;
    if (step) crc_d = crc_step_byte(crc_base, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= '1;
    else if (step) crc_q <= crc_d;
  end

  // index from the register value that includes the current byte
  assign hash_idx = crc_d[CRC_W-1 -: HASH_IDX_W];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import dafl_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = $clog2(4 * (NUM_SLOTS + 2))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              da_start,
  input  logic              da_valid,
  input  logic [7:0]        da_byte,
  output logic              dec_valid,
  output logic              dec_accept
);
  localparam int POS_W = $clog2(ADDR_BYTES + 1);
  localparam int N_CMP = NUM_SLOTS + 1;
  localparam logic [POS_W-1:0] POS_IDLE = POS_W'(ADDR_BYTES);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(ADDR_BYTES - 1);

  mac_addr_t                         station;
  mac_addr_t [NUM_SLOTS-1:0]         mc_addr;
  logic [HASH_WORDS-1:0][WORD_W-1:0] hash_tbl;
  mode_t                             mode;
  logic                              promisc_w;

  dafl_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .station  (station),
    .mc_addr  (mc_addr),
    .hash_tbl (hash_tbl),
    .mode     (mode)
  );

  assign promisc_w = mode.promisc;

  // byte position tracking
  logic [POS_W-1:0] pos_q, pos_d, pos;
  logic             first, in_frame, step, last;

  assign first    = da_valid & da_start;
  assign in_frame = (pos_q < POS_IDLE);
  assign step     = first | (da_valid & in_frame);
  assign pos      = first ? '0 : pos_q;
  assign last     = step & (pos == POS_LAST);

  always_comb begin
    pos_d = pos_q;
    if (step) pos_d = pos + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos_q <= POS_IDLE;
    else if (step) pos_q <= pos_d;
  end

  // exact comparators: index 0 is the station, 1..NUM_SLOTS the slots
  logic [N_CMP-1:0] hit_now;

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    mac_addr_t ref_sel;
    if (g == 0) begin : g_station
      assign ref_sel = station;
    end else begin : g_mcast
      assign ref_sel = mc_addr[g-1];
    end
    dafl_addr_cmp #(.POS_W(POS_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .first    (first),
      .pos      (pos),
      .data     (da_byte),
      .ref_addr (ref_sel),
      .hit_now  (hit_now[g])
    );
  end

  // hash
  logic [HASH_IDX_W-1:0] hash_idx;
  logic [WORD_W-1:0]     hash_word;
  logic                  hash_bit;

  dafl_hash_crc u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .first    (first),
    .data     (da_byte),
    .hash_idx (hash_idx)
  );

  assign hash_word = hash_tbl[hash_idx[5:4]];
  assign hash_bit  = hash_word[4'd15 - hash_idx[3:0]];

  // group bit and broadcast tracking
  logic grp_q, grp_d, bc_q, bc_d, bc_now;

  assign bc_now = (first | bc_q) & (&da_byte);

  always_comb begin
    grp_d = grp_q;
    bc_d  = bc_q;
    if (first) grp_d = da_byte[0];
    if (step)  bc_d  = bc_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= 1'b0;
      bc_q  <= 1'b0;
    end else if (step) begin
      grp_q <= grp_d;
      bc_q  <= bc_d;
    end
  end

  // decision
  logic accept_now, dvalid_d, daccept_d;

  assign accept_now = mode.promisc | bc_now | (|hit_now)
                    | (grp_q & (mode.all_multi | hash_bit));

  always_comb begin
    dvalid_d  = last;
    daccept_d = last & accept_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= dvalid_d;
      dec_accept <= daccept_d;
    end
  end
endmodule

// File: rtl/dafl_checker.sv
module dafl_checker (
  input logic clk,
  input logic rst_n,
  input logic da_start,
  input logic da_valid,
  input logic dec_valid,
  input logic dec_accept,
  input logic promisc
);
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  assert_flag_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept);

  assert_follows_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(da_valid));

  assert_restart_no_decision_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && da_start) |=> !dec_valid);

  assert_promisc_accepts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(promisc)) |-> dec_accept);
endmodule

bind rx_addr_filter dafl_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .da_start   (da_start),
  .da_valid   (da_valid),
  .dec_valid  (dec_valid),
  .dec_accept (dec_accept),
  .promisc    (promisc_w)
);

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [15:0]   cfg_wdata;
  logic          da_start, da_valid;
  logic [7:0]    da_byte;
  logic          dec_valid, dec_accept;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .da_start(da_start), .da_valid(da_valid),
    .da_byte(da_byte), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // byte i of an address sits at bits 8i+7:8i; group = 0 station, k+1 slot k
  task automatic set_addr(input int grp, input logic [47:0] a);
    for (int w = 0; w < 3; w++) wr(4*grp + w, a[16*w +: 16]);
  endtask

  task automatic set_hash(input logic [63:0] t);
    for (int j = 0; j < 4; j++) wr(20 + j, t[16*j +: 16]);
  endtask

  function automatic logic [5:0] hidx(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      c = c ^ {24'h0, a[8*i +: 8]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c[31:26];
  endfunction

  // one-hot table image: word sel at bits 16*sel, bit 15-n inside it
  function automatic logic [63:0] hash_onehot(input logic [5:0] ix);
    logic [63:0] t;
    t = '0;
    t[16*ix[5:4] + (15 - ix[3:0])] = 1'b1;
    return t;
  endfunction

  task automatic send(input logic [47:0] a, input int gap, output logic v, output logic acc);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      da_valid = 1'b1; da_start = (i == 0); da_byte = a[8*i +: 8];
      if (i < 5) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          da_valid = 1'b0; da_start = 1'b0;
        end
      end
    end
    @(negedge clk);
    da_valid = 1'b0; da_start = 1'b0;
    v = dec_valid; acc = dec_accept;
  endtask

  task automatic expect_dec(input string tag, input logic [47:0] a, input logic exp_acc);
    logic v, acc;
    send(a, 0, v, acc);
    check({tag, " strobe"}, v, 1'b1);
    check(tag, acc, exp_acc);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  localparam logic [47:0] STA = 48'h6655_4433_2210;

  initial begin
    logic v, acc;
    cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    da_start = 0; da_valid = 0; da_byte = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", dec_valid, 1'b0);
    check("R1 reset accept", dec_accept, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_dec("R1 reset station zero", 48'h0, 1'b1);
    expect_dec("R1 reset unicast reject", 48'h0000_0000_0102, 1'b0);
    expect_dec("R1 reset multicast reject", 48'h0000_0000_0101, 1'b0);

    // R2 station match and single-byte corruptions
    set_addr(0, STA);
    expect_dec("R2 station accept", STA, 1'b1);
    for (int i = 0; i < 6; i++) begin
      logic [47:0] bad;
      bad = STA;
      bad[8*i + 2] = ~bad[8*i + 2];
      expect_dec("R2 station byte corrupt", bad, 1'b0);
    end

    // R3 broadcast
    expect_dec("R3 broadcast", 48'hFFFF_FFFF_FFFF, 1'b1);

    // R4 exact slots
    for (int k = 0; k < 4; k++) set_addr(k + 1, 48'h0000_5E00_0001 + 48'(k << 24) + 48'(k << 40));
    for (int k = 0; k < 4; k++)
      expect_dec("R4 slot hit", 48'h0000_5E00_0001 + 48'(k << 24) + 48'(k << 40), 1'b1);
    set_addr(3, 48'hFFFF_FFFF_FFFF);
    expect_dec("R4 disabled slot", 48'h0000_5E00_0001 + 48'(2 << 24) + 48'(2 << 40), 1'b0);
    expect_dec("R4 slot miss", 48'h0000_5E00_0001 + 48'(7 << 24), 1'b0);

    // R5 accept-all-multicast
    expect_dec("R5 multicast off", 48'h1234_5678_9A03, 1'b0);
    wr(3, 16'h0002);
    expect_dec("R5 multicast on", 48'h1234_5678_9A03, 1'b1);
    expect_dec("R5 unicast unaffected", 48'h1234_5678_9A02, 1'b0);
    wr(3, 16'h0000);

    // R6 promiscuous
    wr(3, 16'h0001);
    expect_dec("R6 promisc unicast", 48'hABCD_EF01_2344, 1'b1);
    wr(3, 16'h0000);
    expect_dec("R6 promisc off", 48'hABCD_EF01_2344, 1'b0);

    // R7 hash sweep over 64 group addresses
    for (int k = 0; k < 64; k++) begin
      logic [47:0] a;
      logic [5:0]  ix;
      a = {8'(k*7 + 3), 8'(k ^ 8'h5A), 8'(k*37), 8'h11, 8'(k*3), 8'((k << 1) | 1)};
      ix = hidx(a);
      set_hash(hash_onehot(ix));
      expect_dec("R7 hash bit set", a, 1'b1);
      set_hash(~hash_onehot(ix));
      expect_dec("R7 hash bit clear", a, 1'b0);
    end
    set_hash('1);
    expect_dec("R7 unicast ignores hash", 48'h0102_0304_0506, 1'b0);
    set_hash('0);

    // R8 timing of the strobe
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      da_valid = 1'b1; da_start = (i == 0); da_byte = STA[8*i +: 8];
      if (i > 0) check("R8 no early strobe", dec_valid, 1'b0);
    end
    @(negedge clk);
    da_valid = 1'b0; da_start = 1'b0;
    check("R8 strobe after sixth", dec_valid, 1'b1);
    check("R8 accept in strobe", dec_accept, 1'b1);
    @(negedge clk);
    check("R8 strobe one cycle", dec_valid, 1'b0);
    check("R8 accept gated", dec_accept, 1'b0);

    // R9 restart mid-address
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      da_valid = 1'b1; da_start = (i == 0); da_byte = 8'hC0 + 8'(i);
    end
    send(STA, 0, v, acc);
    check("R9 restart strobe", v, 1'b1);
    check("R9 restart accept", acc, 1'b1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      da_valid = 1'b1; da_start = (i == 0); da_byte = STA[8*i +: 8];
    end
    send(48'h0000_0000_0002, 0, v, acc);
    check("R9 restart discards partial", acc, 1'b0);

    // R10 gaps and stray bytes
    send(STA, 2, v, acc);
    check("R10 gap strobe", v, 1'b1);
    check("R10 gap accept", acc, 1'b1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      da_valid = 1'b1; da_start = 1'b0; da_byte = STA[8*(i%6) +: 8];
      check("R10 stray byte ignored", dec_valid, 1'b0);
    end
    @(negedge clk);
    da_valid = 1'b0;
    check("R10 stray no strobe", dec_valid, 1'b0);

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      report();
      $finish;
    end
  end
endmodule